// File: doc/BRIEF.md
# External Memory Strobe Stretch Controller

This block sequences one external data access at a time, timed in machine cycles of four clock states. When a request is accepted, the block pulses the address-latch enable at the start of the first machine cycle. It then drives either the read strobe or the write strobe for a width set by a three-bit stretch code. After a short trailing period it raises a one-clock completion pulse. Larger stretch codes give slow external memories and peripherals longer strobes without any glue logic.

When wait-state control is enabled, an external hold input can lengthen the strobe by whole machine cycles, with no limit on their number. The hold input is checked once per machine cycle, on the last clock of the current strobe window, and only while the strobe is active. The access finishes in the machine cycle in which the hold input is seen low. The wait-enable bit is treated as a static configuration input, because it is changed only through a protected write elsewhere in the chip. Multiplexing of address and data on the pins is handled elsewhere.

Top module: `axs_stretch_ctrl`

## Requirements
- R1: While reset is applied and afterwards with no request, `rd_stb`, `wr_stb`, `ale` and `done` are all low.
- R2: `ale` is high for exactly the first two clocks of an access, which are the first two clocks after the accepting edge. The strobes are low while `ale` is high.
- R3: The strobe asserts on the fifth clock after the accepting edge. Its width is 2 clocks for stretch code 0, and 4×code clocks for codes 1 to 7 (4, 8, 12, 16, 20, 24, 28).
- R4: Without wait extension, `done` is high on clock 4×(code+2) after the accepting edge, so an access lasts code+2 machine cycles.
- R5: `rd_nwr`=1 selects the read strobe and `rd_nwr`=0 selects the write strobe. The other strobe stays low for the whole access, and the two strobes are never high together.
- R6: With `wait_en`=1, `hold_in` is sampled on the last clock of the strobe window. If it is high there, the strobe is extended by 4 clocks and a new last clock follows. This repeats without limit, and `done` moves later by the same amount.
- R7: With `wait_en`=0, `hold_in` has no effect on strobe width or on access length.
- R8: `done` is a single-clock pulse that comes after the strobe has fallen. A request is accepted only in the clock after `done`, so a request held high starts the next access with `ale` two clocks after `done`.
- R9: The stretch code and direction are captured when a request is accepted. Later changes to them during the access have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one clock state per period |
| rst_n | input | 1 | Synchronous active-low reset |
| stretch_sel | input | 3 | Stretch code, captured at request acceptance |
| wait_en | input | 1 | Enables wait extension from `hold_in` (static) |
| hold_in | input | 1 | External wait request, active high |
| req | input | 1 | Access request, accepted when idle |
| rd_nwr | input | 1 | 1 = read access, 0 = write access |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |
| ale | output | 1 | Address-latch enable pulse |
| done | output | 1 | One-clock access completion pulse |

## Verification
The access is exercised with all eight stretch codes, alternating between read and write. This separates the special 2-clock width of code 0 from the linear 4×code widths, and shows that the strobe direction follows `rd_nwr`.

Hold patterns are chosen to land on either side of the strobe's sampling clock. One hold covers two sampling points, one drops one clock before the only sampling point, and one hold is applied with wait control disabled. Together these show that extension counts whole machine cycles, happens only on the sampling clock, and respects the enable.

Directed cases cover:
- changing the code and direction in the middle of an access;
- a request held high across `done`, which fixes the restart spacing.

// File: rtl/axs_pkg.sv
// Shared types for the external access strobe sequencer.
// Assumes: nothing beyond the standard SystemVerilog type system.
package axs_pkg;
    // Access phases: idle, address (ale) cycle, strobe window, trailing period.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_STRB = 2'd2,
        PH_TAIL = 2'd3
    } axs_phase_e;
endpackage

// File: rtl/axs_stretch_decode.sv
// Maps a stretch code to strobe window length and trailing length in clocks.
// Assumes: MC_CLKS is even and at least 4; CNT_W can hold MC_CLKS*(2**CODE_W-1).
module axs_stretch_decode #(
    parameter int CODE_W  = 3,
    parameter int MC_CLKS = 4,
    parameter int CNT_W   = 5
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  strb_len,
    output logic [CNT_W-1:0]  tail_len
);
    localparam logic [CNT_W-1:0] HALF_MC = CNT_W'(MC_CLKS / 2);
    localparam logic [CNT_W-1:0] FULL_MC = CNT_W'(MC_CLKS);

    // Code 0 is the half-cycle special case; others scale linearly.
    always_comb begin
        if (code == '0) begin
            strb_len = HALF_MC;
            tail_len = HALF_MC;
        end else begin
            strb_len = FULL_MC * CNT_W'(code);
            tail_len = FULL_MC;
        end
    end
endmodule

// File: rtl/axs_seq.sv
// Phase sequencer: accepts a request when idle, runs address, strobe and
// trailing phases with one down counter, and extends the strobe by one
// machine cycle when the wait input is high on the strobe's last clock.
// Assumes: wait_en is static during an access.
module axs_seq
    import axs_pkg::*;
#(
    parameter int CODE_W  = 3,
    parameter int MC_CLKS = 4,
    parameter int CNT_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              rd_nwr,
    input  logic [CODE_W-1:0] stretch_sel,
    input  logic              wait_en,
    input  logic              hold_in,
    output axs_phase_e        phase,
    output logic [CNT_W-1:0]  cnt,
    output logic              dir_rd
);
    localparam logic [CNT_W-1:0]  MC_LAST  = CNT_W'(MC_CLKS - 1);
    localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);
    localparam logic [CODE_W-1:0] DEF_CODE = CODE_W'(1);

    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  strb_len;
    logic [CNT_W-1:0]  tail_len;
    logic              cnt_zero;

    axs_stretch_decode #(
        .CODE_W  (CODE_W),
        .MC_CLKS (MC_CLKS),
        .CNT_W   (CNT_W)
    ) u_decode (
        .code     (code_q),
        .strb_len (strb_len),
        .tail_len (tail_len)
    );

    // Terminal count of the current phase.
    assign cnt_zero = (cnt == '0);

    // Phase, counter and captured access parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            code_q <= DEF_CODE;
            dir_rd <= 1'b1;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req) begin
                        phase  <= PH_ADDR;
                        cnt    <= MC_LAST;
                        code_q <= stretch_sel;
                        dir_rd <= rd_nwr;
                    end
                end
                PH_ADDR: begin
                    if (cnt_zero) begin
                        phase <= PH_STRB;
                        cnt   <= strb_len - ONE;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                PH_STRB: begin
                    if (cnt_zero) begin
                        if (wait_en && hold_in) begin
                            cnt <= MC_LAST;
                        end else begin
                            phase <= PH_TAIL;
                            cnt   <= tail_len - ONE;
                        end
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                default: begin
                    if (cnt_zero) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/axs_out_drive.sv
// Derives the bus-control outputs from the sequencer phase and counter.
// Assumes: the address phase loads its counter with MC_CLKS-1 and counts down.
module axs_out_drive
    import axs_pkg::*;
#(
    parameter int MC_CLKS = 4,
    parameter int CNT_W   = 5
) (
    input  axs_phase_e       phase,
    input  logic [CNT_W-1:0] cnt,
    input  logic             dir_rd,
    output logic             ale,
    output logic             rd_stb,
    output logic             wr_stb,
    output logic             done
);
    localparam logic [CNT_W-1:0] ALE_FLOOR = CNT_W'(MC_CLKS / 2);

    // Strobe routing, ale in the first half of the address cycle, end pulse.
    always_comb begin
        ale    = (phase == PH_ADDR) && (cnt >= ALE_FLOOR);
        rd_stb = (phase == PH_STRB) && dir_rd;
        wr_stb = (phase == PH_STRB) && !dir_rd;
        done   = (phase == PH_TAIL) && (cnt == '0);
    end
endmodule

// File: rtl/axs_stretch_ctrl.sv
// Top of the external access strobe stretch controller: one access at a
// time, address-latch pulse, stretched read/write strobe with optional
// wait extension, and a completion pulse.
// Assumes: wait_en is static; req is honoured only when idle.
module axs_stretch_ctrl
    import axs_pkg::*;
#(
    parameter int CODE_W  = 3,
    parameter int MC_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] stretch_sel,
    input  logic              wait_en,
    input  logic              hold_in,
    input  logic              req,
    input  logic              rd_nwr,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              ale,
    output logic              done
);
    localparam int MAX_STRB = MC_CLKS * ((2 ** CODE_W) - 1);
    localparam int CNT_W    = $clog2(MAX_STRB + 1);

    axs_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    logic             dir_rd;

    axs_seq #(
        .CODE_W  (CODE_W),
        .MC_CLKS (MC_CLKS),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .rd_nwr      (rd_nwr),
        .stretch_sel (stretch_sel),
        .wait_en     (wait_en),
        .hold_in     (hold_in),
        .phase       (phase),
        .cnt         (cnt),
        .dir_rd      (dir_rd)
    );

    axs_out_drive #(
        .MC_CLKS (MC_CLKS),
        .CNT_W   (CNT_W)
    ) u_drive (
        .phase  (phase),
        .cnt    (cnt),
        .dir_rd (dir_rd),
        .ale    (ale),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb),
        .done   (done)
    );
endmodule

// File: rtl/axs_stretch_chk.sv
// Protocol checker for the strobe stretch controller, bound to the top.
// Assumes: synchronous active-low reset.
module axs_stretch_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_stb,
    input logic wr_stb,
    input logic ale,
    input logic done
);
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_stb && !wr_stb));

    // R2
    ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (!rd_stb && !wr_stb && !done));

    // R2
    ale_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> ale);

    // R3
    rd_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_stb) |=> rd_stb);

    // R3
    wr_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_stb) |=> wr_stb);
endmodule

bind axs_stretch_ctrl axs_stretch_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_stb (rd_stb),
    .wr_stb (wr_stb),
    .ale    (ale),
    .done   (done)
);

// File: tb/axs_stretch_ctrl_bench.sv
// Self-checking bench for axs_stretch_ctrl: vector table then directed cases.
module axs_stretch_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] stretch_sel = 3'd1;
    logic       wait_en = 1'b0;
    logic       hold_in = 1'b0;
    logic       req = 1'b0;
    logic       rd_nwr = 1'b1;
    logic       rd_stb, wr_stb, ale, done;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    axs_stretch_ctrl u_axs_stretch_ctrl (
        .clk (clk), .rst_n (rst_n), .stretch_sel (stretch_sel),
        .wait_en (wait_en), .hold_in (hold_in), .req (req), .rd_nwr (rd_nwr),
        .rd_stb (rd_stb), .wr_stb (wr_stb), .ale (ale), .done (done)
    );

    // Vector: {code[9:7], rd[6], wait_en[5], hold clocks[4:0]}
    localparam logic [9:0] VEC [12] = '{
        {3'd0, 1'b1, 1'b0, 5'd0},  {3'd1, 1'b0, 1'b0, 5'd0},
        {3'd2, 1'b1, 1'b0, 5'd0},  {3'd3, 1'b0, 1'b0, 5'd0},
        {3'd4, 1'b1, 1'b0, 5'd0},  {3'd5, 1'b0, 1'b0, 5'd0},
        {3'd6, 1'b1, 1'b0, 5'd0},  {3'd7, 1'b0, 1'b0, 5'd0},
        {3'd1, 1'b1, 1'b1, 5'd10}, {3'd0, 1'b0, 1'b1, 5'd2},
        {3'd2, 1'b1, 1'b0, 5'd20}, {3'd3, 1'b0, 1'b1, 5'd11}
    };

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_width(input int code);
        return (code == 0) ? 2 : 4 * code;
    endfunction

    function automatic int exp_ext(input int w, input bit wen, input int h);
        int n = 0;
        if (!wen) return 0;
        while (w - 1 + 4 * n < h) n++;
        return n;
    endfunction

    int m_ale, m_first_ale, m_first_stb, m_rd, m_wr, m_done_idx, m_done_cnt;

    // Runs one access; optionally alters code/direction after acceptance.
    task automatic run_access(input int code, input bit rd, input bit wen,
                              input int hold_clks, input bit alter,
                              input int alt_code, input bit alt_rd);
        int seen = 0;
        m_ale = 0; m_first_ale = -1; m_first_stb = -1;
        m_rd = 0; m_wr = 0; m_done_idx = -1; m_done_cnt = 0;
        @(negedge clk);
        stretch_sel = 3'(code); rd_nwr = rd; wait_en = wen;
        hold_in = 1'b0; req = 1'b1;
        @(posedge clk);
        for (int i = 1; i < 400; i++) begin
            @(negedge clk);
            req = 1'b0;
            if (alter) begin
                stretch_sel = 3'(alt_code);
                rd_nwr = alt_rd;
            end
            if (ale) begin
                m_ale++;
                if (m_first_ale < 0) m_first_ale = i;
            end
            if (rd_stb || wr_stb) begin
                if (m_first_stb < 0) m_first_stb = i;
                hold_in = (seen < hold_clks);
                seen++;
            end else begin
                hold_in = 1'b0;
            end
            if (rd_stb) m_rd++;
            if (wr_stb) m_wr++;
            if (done) begin
                m_done_cnt++;
                m_done_idx = i;
                break;
            end
        end
        hold_in = 1'b0;
    endtask

    initial begin
        #400000;
        fails++;
        tests++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: outputs idle during and after reset
        repeat (3) @(negedge clk);
        check("R1 strobes in reset", int'(rd_stb) + int'(wr_stb), 0);
        check("R1 ale/done in reset", int'(ale) + int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset",
              int'(rd_stb) + int'(wr_stb) + int'(ale) + int'(done), 0);

        foreach (VEC[k]) begin
            int code = int'(VEC[k][9:7]);
            bit rd   = VEC[k][6];
            bit wen  = VEC[k][5];
            int hc   = int'(VEC[k][4:0]);
            int w    = exp_width(code);
            int ext  = exp_ext(w, wen, hc);
            run_access(code, rd, wen, hc, 1'b0, 0, 1'b0);
            check($sformatf("R2 ale clocks v%0d", k), m_ale, 2);
            check($sformatf("R2 ale start v%0d", k), m_first_ale, 1);
            check($sformatf("R3 strobe start v%0d", k), m_first_stb, 5);
            // R6 / R7: extension depends on wait_en and hold timing
            check($sformatf("R3 R6 R7 strobe width v%0d", k),
                  rd ? m_rd : m_wr, w + 4 * ext);
            check($sformatf("R5 other strobe v%0d", k), rd ? m_wr : m_rd, 0);
            check($sformatf("R4 done clock v%0d", k), m_done_idx,
                  4 * (code + 2) + 4 * ext);
        end

        // R9: code and direction changed mid-access are ignored
        run_access(1, 1'b1, 1'b0, 0, 1'b1, 7, 1'b0);
        check("R9 read width kept", m_rd, 4);
        check("R9 no write strobe", m_wr, 0);
        check("R9 done clock kept", m_done_idx, 12);

        // R8: request held high; restart spacing after done
        begin
            int d = -1;
            int a2 = -1;
            int ale_before = 0;
            int dcount = 0;
            @(negedge clk);
            stretch_sel = 3'd1; rd_nwr = 1'b1; wait_en = 1'b0; req = 1'b1;
            @(posedge clk);
            for (int i = 1; i < 60; i++) begin
                @(negedge clk);
                if (done) begin
                    dcount++;
                    if (d < 0) d = i;
                end
                if (ale && d < 0) ale_before++;
                if (ale && d >= 0 && a2 < 0) a2 = i;
            end
            req = 1'b0;
            check("R8 first done clock", d, 12);
            check("R8 no restart before done", ale_before, 2);
            check("R8 restart two clocks after done", a2 - d, 2);
            check("R8 done pulses in window", dcount, 4);
        end
        repeat (20) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule